// File: doc/BRIEF.md
# Task-File Configuration Unlock Sequencer

This block sits beside the host side of an ATA command-block register window. Each host access is given to it as an offset, a size (byte or 16-bit), a direction and a byte of write data. While the window is locked, every access belongs to the drive's task file. The block only watches the traffic for a fixed pattern. That pattern is two back-to-back 16-bit reads of offset 1, followed by a byte write of 0x03 to offset 2. When it appears, the window switches into a hidden configuration space.

While the window is unlocked, byte accesses address five internal configuration bytes instead of the task file:
- a read-cycle timing byte at offset 0
- a write-cycle timing byte at offset 1
- a control byte at offset 3
- a strap byte at offset 5, which is read-only
- a miscellaneous byte at offset 6

Writing 0x83 to offset 2 locks the window again. The block outputs the mode flag, a pass-through flag for the task-file side, read data for configuration reads, and the live contents of every configuration byte.

Top module: `cfg_unlock_seq`

## Requirements
- R1: After reset, `cfgMode` is 0, both timing bytes and the miscellaneous byte are 0x00, the control byte is 0x11 and `ctrlEnable` is 0.
- R2: Two consecutive 16-bit reads of offset 1 followed by a byte write of 0x03 to offset 2 set `cfgMode` to 1 on the clock edge that ends the write. Cycles with `accValid` low do not break the pattern.
- R3: Any access that does not fit the next step of the pattern returns the detector to idle, so the window stays locked. Wrong offsets, sizes, directions and data all count as misfits. A misfit that is itself a 16-bit read of offset 1 counts as the first read of a new attempt.
- R4: While locked, `passThru` equals `accValid`, `cfgRdHit` is 0 and `cfgRdData` is 0x00.
- R5: While unlocked, a byte write to offset 0, 1 or 3 stores the byte, and a byte read of the same offset returns it on `cfgRdData` with `cfgRdHit` high in the same cycle. `passThru` stays 0.
- R6: While unlocked, a byte write of 0x83 to offset 2 clears `cfgMode` at that edge. Any other byte written to offset 2 leaves the window unlocked.
- R7: `ctrlEnable` is 1 exactly while the control byte holds 0x95. The reset value 0x11 is the disabled setting.
- R8: The strap byte reads as {7'b0, `strapPin`} (bit 0: 0 = 33 MHz bus clock, 1 = 25 MHz). Writes to offset 5 have no effect.
- R9: A write to offset 6 stores the data ANDed with 0x7F, so bit 7 of the miscellaneous byte always reads 0.
- R10: Writes to offsets 2 (other than 0x83), 4 and 7 are ignored, and reads of those offsets return 0x00.
- R11: While unlocked, 16-bit accesses change no configuration byte, return 0x00 with `cfgRdHit` low, and are not passed through.
- R12: Configuration bytes keep their values while locked, whatever the task-file traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | A host access is present this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accWide | input | 1 | 1 = 16-bit access, 0 = byte access |
| accOffset | input | 3 | Window offset of the access |
| accWData | input | 8 | Write data (low byte of the access) |
| strapPin | input | 1 | Bus clock rate strap, shown in strap bit 0 |
| cfgMode | output | 1 | Window is in configuration space |
| passThru | output | 1 | Current access belongs to the task file |
| cfgRdHit | output | 1 | Current access is a configuration read |
| cfgRdData | output | 8 | Configuration read data (0x00 when no hit) |
| rdTimingReg | output | 8 | Read-cycle timing byte |
| wrTimingReg | output | 8 | Write-cycle timing byte |
| ctrlReg | output | 8 | Control byte |
| strapReg | output | 8 | Strap byte |
| miscReg | output | 8 | Miscellaneous byte |
| ctrlEnable | output | 1 | Control byte holds the enable value |

## Verification
The unlock detector is driven with the exact pattern, with idle gaps inside it, and with near misses. The near misses are a single read, a byte read in place of a 16-bit read, a wrong magic value, and a third read before the write. Together these separate a detector that counts reads loosely or restarts wrongly from one that follows the restart rule. A repeated four-read run then shows that a restarted attempt can still succeed. While unlocked, every offset class is written and read back: stored, masked, read-only, undefined and the exit offset with a non-exit value. 16-bit traffic is mixed in between. This separates the address decode and write masking from the exit detection. Locked writes after the exit, and a reset while unlocked, confirm that the configuration space is closed to task-file traffic.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

  localparam int OFF_W   = 3;
  localparam int BYTE_W  = 8;
  localparam int NUM_OFF = 1 << OFF_W;

  // Offsets of the configuration bytes inside the unlocked window
  localparam int OFF_RTIME = 0;
  localparam int OFF_WTIME = 1;
  localparam int OFF_CTRL  = 3;
  localparam int OFF_STRAP = 5;
  localparam int OFF_MISC  = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ONE,
    ST_TWO,
    ST_OPEN
  } seqState_t;

  // Strobes from the sequencer control to the register datapath
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [OFF_W-1:0]  addr;
    logic [BYTE_W-1:0] wdata;
  } cfgStrb_t;

  function automatic bit isStored(input int idx);
    return (idx == OFF_RTIME) || (idx == OFF_WTIME) ||
           (idx == OFF_CTRL)  || (idx == OFF_MISC);
  endfunction

endpackage

// File: rtl/cfg_unlock_ctrl.sv
module cfg_unlock_ctrl
  import cfg_unlock_pkg::*;
#(
  parameter logic [OFF_W-1:0]  UNLOCK_OFF  = 3'd1,
  parameter logic [OFF_W-1:0]  MAGIC_OFF   = 3'd2,
  parameter logic [BYTE_W-1:0] MAGIC_ENTER = 8'h03,
  parameter logic [BYTE_W-1:0] MAGIC_LEAVE = 8'h83
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accWide,
  input  logic [OFF_W-1:0]  accOffset,
  input  logic [BYTE_W-1:0] accWData,
  output cfgStrb_t          strb,
  output logic              cfgMode,
  output logic              passThru
);

  seqState_t state, stateNxt;

  logic wideRd;
  logic byteAcc;
  logic enterWr;
  logic leaveWr;

  assign wideRd  = accValid && accWide && !accWrite && (accOffset == UNLOCK_OFF);
  assign byteAcc = accValid && !accWide;
  assign enterWr = byteAcc && accWrite && (accOffset == MAGIC_OFF) &&
                   (accWData == MAGIC_ENTER);
  assign leaveWr = byteAcc && accWrite && (accOffset == MAGIC_OFF) &&
                   (accWData == MAGIC_LEAVE);

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (wideRd) stateNxt = ST_ONE;
      end
      ST_ONE: begin
        if (accValid) stateNxt = wideRd ? ST_TWO : ST_IDLE;
      end
      ST_TWO: begin
        if (accValid) begin
          if (enterWr)     stateNxt = ST_OPEN;
          else if (wideRd) stateNxt = ST_ONE;
          else             stateNxt = ST_IDLE;
        end
      end
      ST_OPEN: begin
        if (leaveWr) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign cfgMode = (state == ST_OPEN);

  always_comb begin
    strb       = '0;
    strb.addr  = accOffset;
    strb.wdata = accWData;
    if (cfgMode && byteAcc) begin
      strb.wrEn = accWrite && !leaveWr;
      strb.rdEn = !accWrite;
    end
  end

  assign passThru = accValid && !cfgMode;

endmodule

// File: rtl/cfg_unlock_dp.sv
module cfg_unlock_dp
  import cfg_unlock_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CTRL_RESET = 8'h11,
  parameter logic [BYTE_W-1:0] CTRL_ON    = 8'h95,
  parameter logic [BYTE_W-1:0] MISC_MASK  = 8'h7f
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrb_t          strb,
  input  logic              strapPin,
  output logic [BYTE_W-1:0] cfgRdData,
  output logic [BYTE_W-1:0] rdTimingReg,
  output logic [BYTE_W-1:0] wrTimingReg,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [BYTE_W-1:0] strapReg,
  output logic [BYTE_W-1:0] miscReg,
  output logic              ctrlEnable
);

  logic [BYTE_W-1:0] regVal [NUM_OFF];

  for (genvar g = 0; g < NUM_OFF; g++) begin : gOff
    if (isStored(g)) begin : gStore
      localparam logic [BYTE_W-1:0] WMASK = (g == OFF_MISC) ? MISC_MASK : '1;
      localparam logic [BYTE_W-1:0] RVAL  = (g == OFF_CTRL) ? CTRL_RESET : '0;
      logic [BYTE_W-1:0] held;
      always_ff @(posedge clk) begin
        if (!rstN) held <= RVAL;
        else if (strb.wrEn && (strb.addr == OFF_W'(g))) held <= strb.wdata & WMASK;
      end
      assign regVal[g] = held;
    end else if (g == OFF_STRAP) begin : gStrap
      assign regVal[g] = {{(BYTE_W-1){1'b0}}, strapPin};
    end else begin : gEmpty
      assign regVal[g] = '0;
    end
  end

  assign cfgRdData   = strb.rdEn ? regVal[strb.addr] : '0;
  assign rdTimingReg = regVal[OFF_RTIME];
  assign wrTimingReg = regVal[OFF_WTIME];
  assign ctrlReg     = regVal[OFF_CTRL];
  assign strapReg    = regVal[OFF_STRAP];
  assign miscReg     = regVal[OFF_MISC];
  assign ctrlEnable  = (regVal[OFF_CTRL] == CTRL_ON);

endmodule

// File: rtl/cfg_unlock_seq.sv
module cfg_unlock_seq
  import cfg_unlock_pkg::*;
#(
  parameter logic [OFF_W-1:0]  UNLOCK_OFF  = 3'd1,
  parameter logic [OFF_W-1:0]  MAGIC_OFF   = 3'd2,
  parameter logic [BYTE_W-1:0] MAGIC_ENTER = 8'h03,
  parameter logic [BYTE_W-1:0] MAGIC_LEAVE = 8'h83,
  parameter logic [BYTE_W-1:0] CTRL_RESET  = 8'h11,
  parameter logic [BYTE_W-1:0] CTRL_ON     = 8'h95,
  parameter logic [BYTE_W-1:0] MISC_MASK   = 8'h7f
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accWide,
  input  logic [OFF_W-1:0]  accOffset,
  input  logic [BYTE_W-1:0] accWData,
  input  logic              strapPin,
  output logic              cfgMode,
  output logic              passThru,
  output logic              cfgRdHit,
  output logic [BYTE_W-1:0] cfgRdData,
  output logic [BYTE_W-1:0] rdTimingReg,
  output logic [BYTE_W-1:0] wrTimingReg,
  output logic [BYTE_W-1:0] ctrlReg,
  output logic [BYTE_W-1:0] strapReg,
  output logic [BYTE_W-1:0] miscReg,
  output logic              ctrlEnable
);

  cfgStrb_t strb;

  cfg_unlock_ctrl #(
    .UNLOCK_OFF (UNLOCK_OFF),
    .MAGIC_OFF  (MAGIC_OFF),
    .MAGIC_ENTER(MAGIC_ENTER),
    .MAGIC_LEAVE(MAGIC_LEAVE)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .accValid (accValid),
    .accWrite (accWrite),
    .accWide  (accWide),
    .accOffset(accOffset),
    .accWData (accWData),
    .strb     (strb),
    .cfgMode  (cfgMode),
    .passThru (passThru)
  );

  cfg_unlock_dp #(
    .CTRL_RESET(CTRL_RESET),
    .CTRL_ON   (CTRL_ON),
    .MISC_MASK (MISC_MASK)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .strapPin   (strapPin),
    .cfgRdData  (cfgRdData),
    .rdTimingReg(rdTimingReg),
    .wrTimingReg(wrTimingReg),
    .ctrlReg    (ctrlReg),
    .strapReg   (strapReg),
    .miscReg    (miscReg),
    .ctrlEnable (ctrlEnable)
  );

  assign cfgRdHit = strb.rdEn;

endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk (
  input logic       clk,
  input logic       rstN,
  input logic       accValid,
  input logic       accWrite,
  input logic       accWide,
  input logic [2:0] accOffset,
  input logic [7:0] accWData,
  input logic       strapPin,
  input logic       cfgMode,
  input logic       passThru,
  input logic       cfgRdHit,
  input logic [7:0] cfgRdData,
  input logic [7:0] rdTimingReg,
  input logic [7:0] wrTimingReg,
  input logic [7:0] ctrlReg,
  input logic [7:0] miscReg
);

  AST_ENTER_NEEDS_MAGIC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgMode) |-> $past(accValid && accWrite && !accWide &&
                             accOffset == 3'd2 && accWData == 8'h03)); // R2

  AST_NO_PASS_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    cfgMode |-> !passThru); // R4

  AST_EXIT_ON_MAGIC: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode && accValid && accWrite && !accWide && accOffset == 3'd2 &&
     accWData == 8'h83) |=> !cfgMode); // R6

  AST_STRAP_READ: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdHit && accOffset == 3'd5) |-> cfgRdData == {7'b0, strapPin}); // R8

  AST_MISC_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdHit && accOffset == 3'd6) |-> !cfgRdData[7]); // R9

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdHit && (accOffset == 3'd2 || accOffset == 3'd4 || accOffset == 3'd7))
      |-> cfgRdData == 8'h00); // R10

  AST_HIT_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdHit |-> (cfgMode && !accWide)); // R11

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMode |=> $stable({rdTimingReg, wrTimingReg, ctrlReg, miscReg})); // R12

endmodule

bind cfg_unlock_seq cfg_unlock_chk uChk (
  .clk        (clk),
  .rstN       (rstN),
  .accValid   (accValid),
  .accWrite   (accWrite),
  .accWide    (accWide),
  .accOffset  (accOffset),
  .accWData   (accWData),
  .strapPin   (strapPin),
  .cfgMode    (cfgMode),
  .passThru   (passThru),
  .cfgRdHit   (cfgRdHit),
  .cfgRdData  (cfgRdData),
  .rdTimingReg(rdTimingReg),
  .wrTimingReg(wrTimingReg),
  .ctrlReg    (ctrlReg),
  .miscReg    (miscReg)
);

// File: tb/tb_cfg_unlock_seq.sv
module tb_cfg_unlock_seq;

  logic       clk = 1'b0;
  logic       rstN;
  logic       accValid, accWrite, accWide;
  logic [2:0] accOffset;
  logic [7:0] accWData;
  logic       strapPin;
  logic       cfgMode, passThru, cfgRdHit, ctrlEnable;
  logic [7:0] cfgRdData, rdTimingReg, wrTimingReg, ctrlReg, strapReg, miscReg;

  int checkCnt = 0;
  int failCnt  = 0;

  logic       obsMode, obsPass, obsHit;
  logic [7:0] obsRd;

  always #5 clk = ~clk;

  cfg_unlock_seq dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accWide(accWide), .accOffset(accOffset), .accWData(accWData),
    .strapPin(strapPin), .cfgMode(cfgMode), .passThru(passThru),
    .cfgRdHit(cfgRdHit), .cfgRdData(cfgRdData), .rdTimingReg(rdTimingReg),
    .wrTimingReg(wrTimingReg), .ctrlReg(ctrlReg), .strapReg(strapReg),
    .miscReg(miscReg), .ctrlEnable(ctrlEnable)
  );

  typedef struct packed {
    logic       v;
    logic       w;
    logic       wd;
    logic [2:0] off;
    logic [7:0] dat;
    logic       eMode;
    logic       ePass;
    logic       eHit;
    logic [7:0] eRd;
    logic [3:0] req;
  } vec_t;

  // expected values are those seen during the access, before its clock edge
  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b0,1'b0,3'd0,8'h00, 1'b0,1'b0,1'b0,8'h00, 4'd4},  // R4 idle
    '{1'b1,1'b0,1'b1,3'd1,8'h00, 1'b0,1'b1,1'b0,8'h00, 4'd4},  // R4 first read
    '{1'b1,1'b0,1'b1,3'd1,8'h00, 1'b0,1'b1,1'b0,8'h00, 4'd4},  // R4 second read
    '{1'b1,1'b1,1'b0,3'd2,8'h03, 1'b0,1'b1,1'b0,8'h00, 4'd2},  // R2 magic write
    '{1'b1,1'b0,1'b0,3'd3,8'h00, 1'b1,1'b0,1'b1,8'h11, 4'd1},  // R1 control reset
    '{1'b1,1'b1,1'b0,3'd0,8'hA5, 1'b1,1'b0,1'b0,8'h00, 4'd5},  // R5
    '{1'b1,1'b0,1'b0,3'd0,8'h00, 1'b1,1'b0,1'b1,8'hA5, 4'd5},  // R5
    '{1'b1,1'b1,1'b0,3'd6,8'hFF, 1'b1,1'b0,1'b0,8'h00, 4'd9},  // R9
    '{1'b1,1'b0,1'b0,3'd6,8'h00, 1'b1,1'b0,1'b1,8'h7F, 4'd9},  // R9
    '{1'b1,1'b1,1'b0,3'd5,8'hFE, 1'b1,1'b0,1'b0,8'h00, 4'd8},  // R8
    '{1'b1,1'b0,1'b0,3'd5,8'h00, 1'b1,1'b0,1'b1,8'h01, 4'd8},  // R8
    '{1'b1,1'b1,1'b0,3'd4,8'h33, 1'b1,1'b0,1'b0,8'h00, 4'd10}, // R10
    '{1'b1,1'b0,1'b0,3'd4,8'h00, 1'b1,1'b0,1'b1,8'h00, 4'd10}, // R10
    '{1'b1,1'b1,1'b0,3'd2,8'h55, 1'b1,1'b0,1'b0,8'h00, 4'd6},  // R6 non-exit
    '{1'b1,1'b0,1'b0,3'd2,8'h00, 1'b1,1'b0,1'b1,8'h00, 4'd10}, // R10
    '{1'b1,1'b0,1'b1,3'd0,8'h00, 1'b1,1'b0,1'b0,8'h00, 4'd11}, // R11
    '{1'b1,1'b1,1'b1,3'd0,8'hBB, 1'b1,1'b0,1'b0,8'h00, 4'd11}, // R11
    '{1'b1,1'b0,1'b0,3'd0,8'h00, 1'b1,1'b0,1'b1,8'hA5, 4'd11}, // R11
    '{1'b1,1'b1,1'b0,3'd3,8'h95, 1'b1,1'b0,1'b0,8'h00, 4'd7},  // R7
    '{1'b1,1'b1,1'b0,3'd2,8'h83, 1'b1,1'b0,1'b0,8'h00, 4'd6},  // R6 exit
    '{1'b1,1'b0,1'b0,3'd0,8'h00, 1'b0,1'b1,1'b0,8'h00, 4'd4},  // R4 locked
    '{1'b1,1'b1,1'b0,3'd0,8'h00, 1'b0,1'b1,1'b0,8'h00, 4'd12}  // R12
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic wd,
                      input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    accValid = v; accWrite = w; accWide = wd; accOffset = o; accWData = d;
    #2;
    obsMode = cfgMode; obsPass = passThru; obsHit = cfgRdHit; obsRd = cfgRdData;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic unlock();
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h03);
  endtask

  task automatic lock();
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h83);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; accValid = 1'b0; accWrite = 1'b0; accWide = 1'b0;
    accOffset = '0; accWData = '0; strapPin = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #2;
    chk("R1 mode", {15'd0, cfgMode}, 16'd0);
    chk("R1 ctrl", {8'd0, ctrlReg}, 16'h11);
    chk("R1 rtime", {8'd0, rdTimingReg}, 16'h00);
    chk("R1 wtime", {8'd0, wrTimingReg}, 16'h00);
    chk("R1 misc", {8'd0, miscReg}, 16'h00);
    chk("R1 enable", {15'd0, ctrlEnable}, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      step(VEC[i].v, VEC[i].w, VEC[i].wd, VEC[i].off, VEC[i].dat);
      tag = $sformatf("vec%0d R%0d", i, VEC[i].req);
      chk({tag, " mode"}, {15'd0, obsMode}, {15'd0, VEC[i].eMode});
      chk({tag, " pass"}, {15'd0, obsPass}, {15'd0, VEC[i].ePass});
      chk({tag, " hit"},  {15'd0, obsHit},  {15'd0, VEC[i].eHit});
      chk({tag, " data"}, {8'd0, obsRd},    {8'd0, VEC[i].eRd});
    end
    idle();
    chk("R12 rtime held", {8'd0, rdTimingReg}, 16'hA5);
    chk("R7 enable on", {15'd0, ctrlEnable}, 16'd1);
    chk("R9 misc held", {8'd0, miscReg}, 16'h7F);
    chk("R8 strap out", {8'd0, strapReg}, 16'h01);

    // R3: single read then magic write
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h03);
    idle();
    chk("R3 one read", {15'd0, cfgMode}, 16'd0);

    // R3: three reads then magic write stays locked
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h03);
    idle();
    chk("R3 three reads", {15'd0, cfgMode}, 16'd0);

    // R3: wrong magic value
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h04);
    idle();
    chk("R3 wrong data", {15'd0, cfgMode}, 16'd0);

    // R3: byte read in place of the second wide read
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b0, 1'b0, 3'd1, 8'h00);
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h03);
    idle();
    chk("R3 byte read", {15'd0, cfgMode}, 16'd0);

    // R3: four reads restart into a fresh attempt that succeeds
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h03);
    idle();
    chk("R3 restart unlock", {15'd0, cfgMode}, 16'd1);
    lock();
    idle();
    chk("R6 locked again", {15'd0, cfgMode}, 16'd0);

    // R2: idle gaps inside the pattern
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    idle();
    step(1'b1, 1'b0, 1'b1, 3'd1, 8'h00);
    idle();
    step(1'b1, 1'b1, 1'b0, 3'd2, 8'h03);
    idle();
    chk("R2 gap unlock", {15'd0, cfgMode}, 16'd1);

    // R7: disable value
    step(1'b1, 1'b1, 1'b0, 3'd3, 8'h11);
    idle();
    chk("R7 enable off", {15'd0, ctrlEnable}, 16'd0);
    step(1'b1, 1'b1, 1'b0, 3'd1, 8'h3C);
    step(1'b1, 1'b0, 1'b0, 3'd1, 8'h00);
    chk("R5 wtime read", {8'd0, obsRd}, 16'h3C);

    // R1: reset while unlocked
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #2;
    chk("R1 reset mode", {15'd0, cfgMode}, 16'd0);
    chk("R1 reset wtime", {8'd0, wrTimingReg}, 16'h00);

    // R8: strap follows the pin
    strapPin = 1'b0;
    unlock();
    step(1'b1, 1'b0, 1'b0, 3'd5, 8'h00);
    chk("R8 strap 33", {8'd0, obsRd}, 16'h00);
    lock();
    idle();

    summary();
    $finish;
  end

endmodule